// File: doc/BRIEF.md
# Self-Timed Byte-Wide EEPROM Control Model

This block is a clocked, cycle-level model of the control logic inside a byte-wide non-volatile memory that a host reaches over an asynchronous-SRAM-style bus. The main array holds 8K bytes. A host writes a byte with one bus cycle. The block then holds the address and data internally and runs a self-timed busy period. In that period it first erases the byte to all ones and then programs the held value. An open-drain ready/busy line, modelled as a pull-low flag, reports the busy period. A host can also read the byte it just wrote to poll for completion.

Two side-band inputs stand in for the high-voltage pins. One selects a separate 32-byte identification row at the top 32 addresses. The other turns a bus write window into a whole-array clear. A low-supply input blocks any programming operation from starting. All enables are active low and are sampled on the rising clock edge. Read data leaves a register one cycle after the address is sampled.

Top module: `selftimed_eeprom`

## Requirements
- R1: A write window is open while `ceN` and `weN` are both low. The address is captured on the first cycle the window is seen open, provided `oeN` is high. Address changes later in the window have no effect.
- R2: The data byte is the last value of `dataIn` sampled while the window was open. The write starts on the first cycle the window is seen closed.
- R3: No write happens if `oeN` is low at any sampled cycle of the window, or if `ceN` stays high while `weN` is low.
- R4: `rbPullLow` is 1 for exactly `WriteCycles` cycles, starting in the cycle after the closing edge. It is 0 out of reset.
- R5: While a write is busy, a read of the pending address (with the same identification-row selection) returns the inverse of the pending byte's bit 7 in bit 7 and zeros in bits 6..0.
- R6: After the busy period, a read returns exactly the written byte, whatever the old contents were. The byte is erased to 0xFF and then programmed.
- R7: `dataOe` is 1 only when `ceN` and `oeN` are low and `weN` is high, registered one cycle. Otherwise `dataOut` is 0.
- R8: With `idMode` high, addresses whose bits 12..5 are all ones (0x1FE0 to 0x1FFF) read and write a separate 32-byte row indexed by bits 4..0. The main array at those addresses is unaffected. Lower addresses still reach the main array.
- R9: A window that opens with `clearMode` high sets every main-array byte to 0xFF. It holds `rbPullLow` at 1 for 2^13 cycles from the cycle after the opening edge and leaves the identification row unchanged.
- R10: While `lowSupply` is high, neither a write nor a clear starts.
- R11: A write window opened while busy is ignored. The pending write completes with its original address and data, and the intruding address is not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ceN | input | 1 | Chip enable, active low |
| oeN | input | 1 | Output enable, active low |
| weN | input | 1 | Write enable, active low |
| addr | input | 13 | Byte address |
| dataIn | input | 8 | Write data from the bus |
| idMode | input | 1 | Selects the identification row for the top 32 addresses |
| clearMode | input | 1 | Turns a write window into a whole-array clear |
| lowSupply | input | 1 | Supply below threshold; blocks programming start |
| dataOut | output | 8 | Read data, 0 when not driven |
| dataOe | output | 1 | Data bus drive enable (0 means high impedance) |
| rbPullLow | output | 1 | 1 while the open-drain ready/busy line is pulled low |

## Verification
Two functions can land in the same cycle: the final programming strobe of a write, and a polling read of that same address. The bench polls the pending address on every cycle of the busy period. For each read it predicts the polling value or the true byte from the busy flag seen just before the sampling edge. The poll taken in the last busy cycle must still show the inverted bit 7, and the very next read must show the full new byte. A second collision comes from opening a fresh write window while the self-timed write runs. That write is judged by the final contents of both the pending and the intruding addresses.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;
  // strobes from the sequencer to the storage datapath
  typedef struct packed {
    logic capAddr;    // take address and row selection
    logic capData;    // take the data byte
    logic wrBusy;     // a byte write is in flight
    logic eraseByte;  // drive the held byte location to all ones
    logic progByte;   // program the held byte location
    logic clearByte;  // sweep strobe of a whole-array clear
  } ctlStrobes_t;
endpackage

// File: rtl/eeprom_ctrl.sv
module eeprom_ctrl
  import eeprom_pkg::*;
#(
  parameter int AddrW       = 13,
  parameter int WriteCycles = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ceN,
  input  logic             oeN,
  input  logic             weN,
  input  logic             clearMode,
  input  logic             lowSupply,
  output ctlStrobes_t      strb,
  output logic [AddrW-1:0] sweepAddr,
  output logic             rbPullLow
);
  localparam int TimW = (WriteCycles > 1) ? $clog2(WriteCycles) : 1;
  localparam int CntW = (TimW > AddrW) ? TimW : AddrW;
  localparam logic [CntW-1:0] LastWr  = CntW'(WriteCycles - 1);
  localparam logic [CntW-1:0] LastClr = CntW'((64'd1 << AddrW) - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_WRITE, ST_CLEAR} ctlState_t;

  ctlState_t       state;
  logic [CntW-1:0] cnt;
  logic            prevWin, armed, armNext;
  logic            winOpen, opening, closing, isIdle;
  logic            startWrite, startClear;

  assign winOpen = !ceN && !weN;
  assign opening = winOpen && !prevWin;
  assign closing = !winOpen && prevWin;
  assign isIdle  = (state == ST_IDLE);

  always_comb begin
    if (!isIdle)       armNext = 1'b0;
    else if (opening)  armNext = !clearMode && oeN && !lowSupply;
    else if (winOpen)  armNext = armed && oeN;
    else               armNext = 1'b0;
  end

  assign startClear = isIdle && opening && clearMode && !lowSupply;
  assign startWrite = isIdle && closing && armed && !lowSupply;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      prevWin <= 1'b0;
      armed   <= 1'b0;
    end else begin
      prevWin <= winOpen;
      armed   <= armNext;
      case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (startClear)      state <= ST_CLEAR;
          else if (startWrite) state <= ST_WRITE;
        end
        ST_WRITE: begin
          if (cnt == LastWr) begin
            state <= ST_IDLE;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        ST_CLEAR: begin
          if (cnt == LastClr) begin
            state <= ST_IDLE;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.capAddr   = isIdle && opening && armNext;
    strb.capData   = armNext && winOpen;
    strb.wrBusy    = (state == ST_WRITE);
    strb.eraseByte = (state == ST_WRITE) && (cnt == '0);
    strb.progByte  = (state == ST_WRITE) && (cnt == LastWr);
    strb.clearByte = (state == ST_CLEAR);
  end

  assign sweepAddr = cnt[AddrW-1:0];
  assign rbPullLow = !isIdle;

  AST_NO_START_LOW_SUPPLY: assert property (@(posedge clk) disable iff (!rstN)
    (isIdle && lowSupply) |=> (state == ST_IDLE)); // R10

  AST_WRITE_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WRITE) |-> (cnt <= LastWr)); // R4

  AST_ONE_ARRAY_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.eraseByte, strb.progByte, strb.clearByte})); // R6

  AST_BUSY_AFTER_CLOSE: assert property (@(posedge clk) disable iff (!rstN)
    startWrite |=> rbPullLow); // R4
endmodule

// File: rtl/eeprom_dp.sv
module eeprom_dp
  import eeprom_pkg::*;
#(
  parameter int AddrW  = 13,
  parameter int DataW  = 8,
  parameter int IdRowW = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobes_t      strb,
  input  logic [AddrW-1:0] sweepAddr,
  input  logic             ceN,
  input  logic             oeN,
  input  logic             weN,
  input  logic [AddrW-1:0] addr,
  input  logic [DataW-1:0] dataIn,
  input  logic             idMode,
  output logic [DataW-1:0] dataOut,
  output logic             dataOe
);
  localparam int MainDepth = 1 << AddrW;
  localparam int IdDepth   = 1 << IdRowW;

  logic [DataW-1:0] mainMem [MainDepth];
  logic [DataW-1:0] idRow   [IdDepth];

  logic [AddrW-1:0] latchAddr;
  logic [DataW-1:0] latchData;
  logic             latchId;
  logic             idHit, readSel, pollHit;
  logic [DataW-1:0] wrVal, pollVal;

  assign idHit   = idMode && (&addr[AddrW-1:IdRowW]);
  assign readSel = !ceN && !oeN && weN;
  assign pollHit = strb.wrBusy && (addr == latchAddr) && (idHit == latchId);
  assign pollVal = {~latchData[DataW-1], {(DataW-1){1'b0}}};
  assign wrVal   = strb.eraseByte ? {DataW{1'b1}} : latchData;

  // host-side latches
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchAddr <= '0;
      latchData <= '0;
      latchId   <= 1'b0;
    end else begin
      if (strb.capAddr) begin
        latchAddr <= addr;
        latchId   <= idHit;
      end
      if (strb.capData) latchData <= dataIn;
    end
  end

  // array write port
  always_ff @(posedge clk) begin
    if (strb.clearByte) mainMem[sweepAddr] <= {DataW{1'b1}};
    else if (strb.eraseByte || strb.progByte) begin
      if (latchId) idRow[latchAddr[IdRowW-1:0]] <= wrVal;
      else         mainMem[latchAddr]          <= wrVal;
    end
  end

  // registered read port
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataOut <= '0;
      dataOe  <= 1'b0;
    end else begin
      dataOe <= readSel;
      if (!readSel)    dataOut <= '0;
      else if (pollHit) dataOut <= pollVal;
      else if (idHit)   dataOut <= idRow[addr[IdRowW-1:0]];
      else              dataOut <= mainMem[addr];
    end
  end

  AST_HELD_WRITE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrBusy |=> ($stable(latchAddr) && $stable(latchData) && $stable(latchId))); // R11

  AST_DESELECT_HIZ: assert property (@(posedge clk) disable iff (!rstN)
    ceN |=> (!dataOe && (dataOut == '0))); // R7
endmodule

// File: rtl/selftimed_eeprom.sv
module selftimed_eeprom
  import eeprom_pkg::*;
#(
  parameter int AddrW       = 13,
  parameter int DataW       = 8,
  parameter int IdRowW      = 5,
  parameter int WriteCycles = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ceN,
  input  logic             oeN,
  input  logic             weN,
  input  logic [AddrW-1:0] addr,
  input  logic [DataW-1:0] dataIn,
  input  logic             idMode,
  input  logic             clearMode,
  input  logic             lowSupply,
  output logic [DataW-1:0] dataOut,
  output logic             dataOe,
  output logic             rbPullLow
);
  ctlStrobes_t      strb;
  logic [AddrW-1:0] sweepAddr;

  eeprom_ctrl #(.AddrW(AddrW), .WriteCycles(WriteCycles)) u_ctrl (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN),
    .clearMode(clearMode), .lowSupply(lowSupply),
    .strb(strb), .sweepAddr(sweepAddr), .rbPullLow(rbPullLow)
  );

  eeprom_dp #(.AddrW(AddrW), .DataW(DataW), .IdRowW(IdRowW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .sweepAddr(sweepAddr),
    .ceN(ceN), .oeN(oeN), .weN(weN), .addr(addr), .dataIn(dataIn),
    .idMode(idMode), .dataOut(dataOut), .dataOe(dataOe)
  );

  AST_NO_DRIVE_DURING_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !weN |=> !dataOe); // R7
endmodule

// File: tb/selftimed_eeprom_tb.sv
`timescale 1ns/100ps
module selftimed_eeprom_tb;
  localparam int AW   = 13;
  localparam int DW   = 8;
  localparam int WCYC = 16;
  localparam int CLRN = 1 << AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ceN = 1'b1, oeN = 1'b1, weN = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dataIn = '0;
  logic idMode = 1'b0, clearMode = 1'b0, lowSupply = 1'b0;
  logic [DW-1:0] dataOut;
  logic dataOe, rbPullLow;

  int checks = 0;
  int failures = 0;
  logic issue = 1'b0;

  typedef struct { logic [DW-1:0] data; logic oe; string req; } expItem_t;
  expItem_t expQ[$];

  always #2.5 clk = ~clk;

  selftimed_eeprom #(.AddrW(AW), .DataW(DW), .WriteCycles(WCYC)) u_dut (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN), .addr(addr),
    .dataIn(dataIn), .idMode(idMode), .clearMode(clearMode), .lowSupply(lowSupply),
    .dataOut(dataOut), .dataOe(dataOe), .rbPullLow(rbPullLow)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // monitor: compares each issued read one edge later
  initial begin
    forever begin
      logic due;
      expItem_t it;
      @(posedge clk);
      due = issue;
      #1;
      if (due) begin
        if (expQ.size() == 0) chk(1'b0, "scoreboard-empty", 0, 1);
        else begin
          it = expQ.pop_front();
          chk(dataOe === it.oe, {it.req, " oe"}, int'(dataOe), int'(it.oe));
          chk(dataOut === it.data, {it.req, " data"}, int'(dataOut), int'(it.data));
        end
      end
    end
  end

  task automatic issueRead(input logic [AW-1:0] a, input logic id, input logic ceV,
                           input logic oeV, input logic [DW-1:0] exp, input string req);
    expItem_t it;
    ceN = ceV; oeN = oeV; weN = 1'b1; addr = a; idMode = id;
    it.oe = !ceV && !oeV;
    it.data = it.oe ? exp : '0;
    it.req = req;
    expQ.push_back(it);
    issue = 1'b1;
    @(negedge clk);
    issue = 1'b0;
    ceN = 1'b1; oeN = 1'b1;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic id, input logic [DW-1:0] exp,
                    input string req);
    issueRead(a, id, 1'b0, 1'b0, exp, req);
  endtask

  // one bus write window; junk data first, junk address after opening
  task automatic pulse(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic id,
                       input logic oeV);
    @(negedge clk);
    addr = a; dataIn = ~d; idMode = id; oeN = oeV; weN = 1'b0; ceN = 1'b1;
    @(negedge clk);
    ceN = 1'b0;
    @(negedge clk);
    addr = a ^ 13'h0155; dataIn = d;
    @(negedge clk);
    ceN = 1'b1;
    @(negedge clk);
    weN = 1'b1; oeN = 1'b1; addr = a;
  endtask

  task automatic writeByte(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic id);
    int n;
    pulse(a, d, id, 1'b1);
    n = 0;
    while (rbPullLow === 1'b1 && n < 1000) begin
      issueRead(a, id, 1'b0, 1'b0, {~d[DW-1], {(DW-1){1'b0}}}, "R5 poll");
      n++;
    end
    chk(n == WCYC, "R4 busy length", n, WCYC);
    rd(a, id, d, "R6 R2 final data");
  endtask

  task automatic waitIdle();
    int g;
    g = 0;
    while (rbPullLow === 1'b1 && g < 20000) begin
      @(negedge clk);
      g++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL R4 watchdog actual=hung expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(rbPullLow === 1'b0, "R4 reset ready", int'(rbPullLow), 0);
    chk(dataOe === 1'b0, "R7 reset hiz", int'(dataOe), 0);

    // identification row entry written before the clear
    writeByte(13'h1FE3, 8'h3C, 1'b1);

    // R9 whole-array clear
    @(negedge clk);
    ceN = 1'b0; weN = 1'b0; oeN = 1'b1; clearMode = 1'b1;
    @(negedge clk);
    ceN = 1'b1; weN = 1'b1; clearMode = 1'b0;
    n = 0;
    while (rbPullLow === 1'b1 && n < 20000) begin
      n++;
      @(negedge clk);
    end
    chk(n == CLRN, "R9 clear busy length", n, CLRN);
    rd(13'h0000, 1'b0, 8'hFF, "R9 main low");
    rd(13'h1ABC, 1'b0, 8'hFF, "R9 main mid");
    rd(13'h1FE3, 1'b0, 8'hFF, "R9 R8 main under id row");
    rd(13'h1FE3, 1'b1, 8'h3C, "R9 R8 id row kept");

    // R1 R2 R5 R6 basic writes
    writeByte(13'h0010, 8'hA5, 1'b0);
    rd(13'h0010 ^ 13'h0155, 1'b0, 8'hFF, "R1 late address ignored");
    writeByte(13'h0010, 8'h5A, 1'b0);
    writeByte(13'h0011, 8'h00, 1'b0);
    rd(13'h0011, 1'b0, 8'h00, "R6 all zero byte");

    // R3 inhibit: output enable low, then chip enable high
    pulse(13'h0012, 8'h33, 1'b0, 1'b0);
    chk(rbPullLow === 1'b0, "R3 oe low no busy", int'(rbPullLow), 0);
    rd(13'h0012, 1'b0, 8'hFF, "R3 oe low no write");
    @(negedge clk);
    ceN = 1'b1; weN = 1'b0; oeN = 1'b1; addr = 13'h0013; dataIn = 8'h44;
    repeat (3) @(negedge clk);
    weN = 1'b1;
    @(negedge clk);
    chk(rbPullLow === 1'b0, "R3 ce high no busy", int'(rbPullLow), 0);
    rd(13'h0013, 1'b0, 8'hFF, "R3 ce high no write");

    // R10 low supply blocks write and clear
    lowSupply = 1'b1;
    pulse(13'h0014, 8'h55, 1'b0, 1'b1);
    chk(rbPullLow === 1'b0, "R10 write blocked", int'(rbPullLow), 0);
    @(negedge clk);
    ceN = 1'b0; weN = 1'b0; clearMode = 1'b1;
    @(negedge clk);
    ceN = 1'b1; weN = 1'b1; clearMode = 1'b0;
    chk(rbPullLow === 1'b0, "R10 clear blocked", int'(rbPullLow), 0);
    lowSupply = 1'b0;
    rd(13'h0014, 1'b0, 8'hFF, "R10 no write");
    rd(13'h0010, 1'b0, 8'h5A, "R10 no clear");

    // R7 output gating
    issueRead(13'h0010, 1'b0, 1'b1, 1'b0, 8'h00, "R7 ce high hiz");
    issueRead(13'h0010, 1'b0, 1'b0, 1'b1, 8'h00, "R7 oe high hiz");

    // R11 intruding window while busy
    pulse(13'h0020, 8'h11, 1'b0, 1'b1);
    chk(rbPullLow === 1'b1, "R11 first write busy", int'(rbPullLow), 1);
    pulse(13'h0021, 8'h99, 1'b0, 1'b1);
    waitIdle();
    rd(13'h0020, 1'b0, 8'h11, "R11 pending write kept");
    rd(13'h0021, 1'b0, 8'hFF, "R11 intruder dropped");

    // R8 identification row
    writeByte(13'h1FE5, 8'h77, 1'b1);
    rd(13'h1FE5, 1'b0, 8'hFF, "R8 main untouched");
    rd(13'h1FE3, 1'b1, 8'h3C, "R8 other id byte");
    writeByte(13'h0030, 8'h42, 1'b1);
    rd(13'h0030, 1'b0, 8'h42, "R8 low address reaches main");

    repeat (3) @(negedge clk);
    if (expQ.size() != 0) chk(1'b0, "scoreboard-leftover", expQ.size(), 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule